// File: doc/BRIEF.md
# Retriggerable BCD Watchdog Interval Timer

This block counts down a period of up to 99.99 seconds, programmed as packed BCD in two host registers: one holding the hundredths and tenths of a second, the other holding the units and tens of seconds. A hundredths-of-a-second tick input drives the countdown. When the count runs out, the block raises a sticky watchdog flag and reloads itself from the registers. It therefore also works as a repeating interval alarm.

Any host write to either register restarts the countdown from the full programmed period and drops the pending flag. Software that keeps writing before the period ends never sees the flag, which makes the block a watchdog. A mask input from the surrounding command logic keeps the flag from reaching the interrupt output. The raw flag itself is still kept.

Reads return the programmed period values and never the running count. A programmed period of zero stops the timer completely.

Top module: `wdt_countdown`

## Requirements
- R1: After reset, both registers read 8'h00, the flag is 0, the interrupt output is 0 and the timer is idle.
- R2: A write stores packed BCD with the low nibble as the units digit. Any nibble above 9 is stored as 9. Register select 0 is the hundredths register (tenths in bits 7:4, hundredths in bits 3:0). Register select 1 is the seconds register (tens in bits 7:4, units in bits 3:0).
- R3: The count drops by one hundredth on each cycle where the tick is high. It borrows in BCD across all four digits. Cycles without a tick leave it unchanged.
- R4: With a non-zero period of N hundredths, the flag goes to 1 on the clock edge of the N-th tick after the last write.
- R5: At expiry the count reloads the programmed period, so the flag event repeats every N ticks. The flag stays at 1 until the next write.
- R6: A write to either register clears the flag and restarts the count from the period formed by both registers, including the value just written. A write wins over a tick in the same cycle.
- R7: With a period of 00.00 the flag never rises, however many ticks arrive.
- R8: The interrupt output equals the flag while the mask input is 0, and it is 0 while the mask input is 1.
- R9: The read data always shows the programmed register value selected by the register select, in the same cycle. The running count never appears there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hs_tick_i | input | 1 | One-cycle hundredths-of-a-second tick |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select for read and write (0 hundredths, 1 seconds) |
| wr_data_i | input | 8 | Packed BCD write data |
| rd_data_o | output | 8 | Programmed value of the selected register |
| alarm_mask_i | input | 1 | Masks the flag from the interrupt output |
| wd_flag_o | output | 1 | Sticky watchdog expiry flag |
| wd_irq_o | output | 1 | Flag gated by the mask, to the interrupt router |

## Verification
Short periods with a tick every cycle show whether expiry lands on exactly the N-th tick and then repeats. Periods of 01.00 and 99.99 exercise the borrow chain across every digit boundary, because a wrong borrow shifts the expiry cycle. Writes placed mid-count and in the same cycle as a tick show restart, flag clearing and write priority. A zero period separates a stopped timer from one that wraps. Random sparse ticks with occasional random writes, including non-BCD nibbles, compare the flag timing, the masked interrupt and the read data against a model of the period in integer ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned BCD_W = 4;

    typedef logic [BCD_W-1:0] bcd_t;

    // Largest legal BCD digit; anything above is clamped to it.
    localparam bcd_t BCD_MAX = 4'd9;

    function automatic bcd_t bcd_clamp(input bcd_t d);
        return (d > BCD_MAX) ? BCD_MAX : d;
    endfunction

endpackage

// File: rtl/wdt_load_regs.sv
module wdt_load_regs
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 2,
    localparam int unsigned SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int unsigned DIG_PER = DATA_W / BCD_W,
    localparam int unsigned LOAD_W  = NUM_REGS * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [LOAD_W-1:0] load_d_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } regs_st_t;

    regs_st_t            st_d, st_q;
    logic [DATA_W-1:0]   wr_sat;

    // Clamp each written nibble to a legal BCD digit.
    for (genvar g = 0; g < DIG_PER; g++) begin : g_sat
        assign wr_sat[g*BCD_W +: BCD_W] = bcd_clamp(wr_data_i[g*BCD_W +: BCD_W]);
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.regs[sel_i] = wr_sat;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.regs[sel_i];
    assign load_d_o  = st_d.regs;

    // R2
    stored_bcd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_en_i) |-> (rd_data_o[BCD_W-1:0] <= BCD_MAX || $past(sel_i) != sel_i));

    // R9
    read_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(wr_en_i) && $stable(sel_i)) |-> $stable(rd_data_o));

endmodule

// File: rtl/wdt_bcd_down.sv
module wdt_bcd_down
    import wdt_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 4,
    localparam int unsigned CNT_W     = NUM_DIGITS * BCD_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             fire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    cnt_st_t           st_d, st_q;
    logic [NUM_DIGITS-1:0] borrow;
    logic [CNT_W-1:0]  dec_val;
    logic              at_end;
    logic              armed;

    assign borrow[0] = 1'b1;

    // BCD decrement with a borrow chain from the hundredths digit upward.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
        logic [BCD_W-1:0] dig;
        assign dig = st_q.cnt[g*BCD_W +: BCD_W];
        assign dec_val[g*BCD_W +: BCD_W] =
            !borrow[g]   ? dig :
            (dig == '0)  ? BCD_MAX : dig - 1'b1;
        if (g < NUM_DIGITS - 1) begin : g_chain
            assign borrow[g+1] = borrow[g] && (dig == '0);
        end

        // R3
        digit_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            st_q.cnt[g*BCD_W +: BCD_W] <= BCD_MAX);
    end

    assign armed  = |load_val_i;
    assign at_end = (st_q.cnt == CNT_ONE) || (st_q.cnt == '0);
    assign fire_o = tick_i && !restart_i && armed && at_end;

    always_comb begin
        st_d = st_q;
        if (restart_i || fire_o) begin
            st_d.cnt = load_val_i;
        end else if (tick_i && armed) begin
            st_d.cnt = dec_val;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    reload_after_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(fire_o) |-> st_q.cnt == $past(load_val_i));

    // R3
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!tick_i && !restart_i) |-> $stable(st_q.cnt));

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 2,
    localparam int unsigned SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int unsigned LOAD_W  = NUM_REGS * DATA_W,
    localparam int unsigned DIGITS  = LOAD_W / BCD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hs_tick_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  reg_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              alarm_mask_i,
    output logic              wd_flag_o,
    output logic              wd_irq_o
);

    typedef struct packed {
        logic flag;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [LOAD_W-1:0] load_d;
    logic              fire;

    wdt_load_regs #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .sel_i     (reg_sel_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .load_d_o  (load_d)
    );

    wdt_bcd_down #(
        .NUM_DIGITS (DIGITS)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (hs_tick_i),
        .restart_i  (wr_en_i),
        .load_val_i (load_d),
        .fire_o     (fire)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.flag = 1'b0;
        end else if (fire) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wd_flag_o = st_q.flag;
    assign wd_irq_o  = st_q.flag && !alarm_mask_i;

    // R4
    flag_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wd_flag_o) |-> $past(hs_tick_i && !wr_en_i));

    // R6
    wr_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_en_i) |-> !wd_flag_o);

    // R7
    zero_period_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wd_flag_o) |-> $past(|load_d));

    // R8
    mask_blocks_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alarm_mask_i |-> !wd_irq_o);

endmodule

// File: tb/wdt_countdown_bench.sv
module wdt_countdown_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       mask = 1'b0;
    logic       flag;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string tag   = "R4";

    // Model state
    logic [7:0] m_reg [2];
    int m_cnt  = 0;
    bit m_flag = 1'b0;

    always #10 clk = ~clk;

    wdt_countdown u_wdt_countdown (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .hs_tick_i    (tick),
        .wr_en_i      (wr),
        .reg_sel_i    (sel),
        .wr_data_i    (wdata),
        .rd_data_o    (rdata),
        .alarm_mask_i (mask),
        .wd_flag_o    (flag),
        .wd_irq_o     (irq)
    );

    function automatic logic [7:0] sat_byte(input logic [7:0] b);
        logic [3:0] hi, lo;
        hi = (b[7:4] > 4'd9) ? 4'd9 : b[7:4];
        lo = (b[3:0] > 4'd9) ? 4'd9 : b[3:0];
        return {hi, lo};
    endfunction

    function automatic int period_ticks();
        return 1000 * int'(m_reg[1][7:4]) + 100 * int'(m_reg[1][3:0])
             + 10 * int'(m_reg[0][7:4]) + int'(m_reg[0][3:0]);
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: inputs held from negedge, model updated at posedge, outputs checked at negedge.
    task automatic step(input bit w, input bit s, input logic [7:0] d, input bit t, input bit m);
        int per;
        wr = w; sel = s; wdata = d; tick = t; mask = m;
        @(posedge clk);
        if (w) begin
            m_reg[s] = sat_byte(d);
            m_cnt    = period_ticks();
            m_flag   = 1'b0;
        end else begin
            per = period_ticks();
            if (t && per != 0) begin
                if (m_cnt <= 1) begin
                    m_flag = 1'b1;
                    m_cnt  = per;
                end else begin
                    m_cnt--;
                end
            end
        end
        @(negedge clk);
        check(tag, int'(flag), int'(m_flag), "flag");
        check("R8", int'(irq), int'(m_flag && !m), "irq");
        check("R9", int'(rdata), int'(m_reg[s]), "read data");
        wr = 1'b0; tick = 1'b0;
    endtask

    task automatic load(input logic [7:0] hund, input logic [7:0] secs);
        step(1'b1, 1'b0, hund, 1'b0, 1'b0);
        step(1'b1, 1'b1, secs, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    // Runs ticks until the flag rises; returns the tick count.
    task automatic ticks_to_flag(input int limit, output int seen);
        seen = 0;
        while (!flag && seen < limit) begin
            step(1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
            seen++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seen;
        void'($urandom(32'h5eed_1234));
        m_reg[0] = '0; m_reg[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        sel = 1'b0; #1;
        check("R1", int'(rdata), 0, "hundredths reg after reset");
        sel = 1'b1; #1;
        check("R1", int'(rdata), 0, "seconds reg after reset");
        check("R1", int'(flag), 0, "flag after reset");
        check("R1", int'(irq), 0, "irq after reset");

        // R7: zero period never fires
        tag = "R7";
        ticks(300);
        check("R7", int'(flag), 0, "flag with zero period");

        // R2: BCD clamp on write
        tag = "R2";
        step(1'b1, 1'b0, 8'hAF, 1'b0, 1'b0);
        check("R2", int'(rdata), 8'h99, "clamped hundredths");
        step(1'b1, 1'b1, 8'h3C, 1'b0, 1'b0);
        check("R2", int'(rdata), 8'h39, "clamped seconds");

        // R4 / R5: period 00.05 fires on 5th tick, then every 5
        tag = "R4";
        load(8'h05, 8'h00);
        ticks(4);
        check("R4", int'(flag), 0, "flag before 5th tick");
        ticks(1);
        check("R4", int'(flag), 1, "flag on 5th tick");
        tag = "R5";
        ticks(12);
        check("R5", int'(flag), 1, "flag sticky across reloads");
        load(8'h05, 8'h00);
        ticks(3);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0); // idle cycle, count holds
        ticks(1);
        check("R3", int'(flag), 0, "idle cycle does not count");
        ticks(1);
        check("R5", int'(flag), 1, "expiry after reload period");

        // R3: borrow across digits, 01.00 = 100 ticks
        tag = "R3";
        load(8'h00, 8'h01);
        ticks_to_flag(200, seen);
        check("R3", seen, 100, "ticks to expiry for 01.00");
        // R3: maximum 99.99
        load(8'h99, 8'h99);
        ticks_to_flag(12000, seen);
        check("R3", seen, 9999, "ticks to expiry for 99.99");

        // R6: refresh mid-count restarts; write beats a tick
        tag = "R6";
        load(8'h10, 8'h00);
        for (int k = 0; k < 5; k++) begin
            ticks(8);
            step(1'b1, 1'b0, 8'h10, 1'b1, 1'b0); // write with tick
        end
        check("R6", int'(flag), 0, "refreshed watchdog never fires");
        ticks_to_flag(50, seen);
        check("R6", seen, 10, "full period after refresh");
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0);
        check("R6", int'(flag), 0, "write clears flag");

        // R8: mask gating
        tag = "R8";
        load(8'h02, 8'h00);
        ticks(2);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        check("R8", int'(irq), 0, "masked irq");
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R8", int'(irq), 1, "unmasked irq");

        // Random mix
        tag = "R4";
        for (int i = 0; i < 20000; i++) begin
            bit w, s, t, m;
            logic [7:0] d;
            w = ($urandom % 150) == 0;
            s = $urandom % 2;
            d = s ? 8'($urandom % 3) : 8'($urandom);
            t = ($urandom % 4) != 0;
            m = ($urandom % 5) == 0;
            step(w, s, d, t, m);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule